// File: doc/BRIEF.md
# Oversampled FSK Chip Slicer with Averaging Threshold

This block turns the signed output of an FSK frequency discriminator into binary chips. A first-order exponential averaging filter follows the discriminator output during a DC-balanced preamble: alternating 0/1 chips, which in Manchester mode appear as 0110 0110… chips. The filter's output is the decision threshold. Each chip spans eight discriminator samples. Every sample is compared with the threshold, and a majority vote over the central samples of the chip gives the chip value.

The threshold must stop tracking once payload data begins, because payload data need not be DC-balanced. The block offers three ways to handle this:
- Manual lock: a control bit freezes the filter.
- Automatic lock: a chip timer started by receive enable freezes the filter once its interval ends. A two-bit settling code sets both the filter's time constant and that interval.
- Free-running: the filter never locks, which suits Manchester data.

When receive enable falls, the filter, the timer, the lock and the chip phase all restart.

Top module: `fsk_slicer`

## Requirements
- R1: After reset, and whenever `rx_en` is low, `threshold` reads 0, `locked` reads 0 and `chip_valid` stays 0.
- R2: When `rx_en` is high, a strobe arrives and the filter is not locked, the average updates as avg ← avg + ((x − avg) >>> k). Here k = 3 + `settle_sel` (3, 4, 5, 6) and >>> is an arithmetic (floor) shift. `threshold` shows the new value in the cycle after the strobe. Without a strobe the average holds.
- R3: A sample votes 1 when it is strictly greater than the threshold in force in the strobe's cycle, which is the value before that strobe's update. An equal sample votes 0.
- R4: Strobes are numbered 0 to 7 within a chip, counting from the rise of `rx_en`. Only samples 2 through 6 vote. `chip_out` is 1 when at least 3 of those 5 votes are 1. `chip_valid` pulses for one cycle in the cycle after strobe 7.
- R5: When `lock_mode` is 1 (manual), `locked` equals `lock_req` while `rx_en` is high. `lock_req` = 0 lets the filter run free.
- R6: When `lock_mode` is 0 (automatic), `locked` rises in the cycle after strobe 7 of chip number 16·2^`settle_sel` (16, 32, 64 or 128) counted from `rx_en`. The strobe that completes that chip still updates the average.
- R7: While `locked` is high, strobes leave `threshold` unchanged.
- R8: Lowering `rx_en` for one cycle clears the average, the chip timer, the automatic lock and the chip phase. Samples strobed while `rx_en` is low have no effect.
- R9: In automatic mode `lock_req` has no effect on `locked` or on `threshold`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable; its rise starts the chip timer |
| smp_valid | input | 1 | Discriminator sample strobe |
| smp_data | input | SMP_W | Signed discriminator sample |
| lock_mode | input | 1 | 1 = manual lock, 0 = automatic lock |
| lock_req | input | 1 | Manual lock request |
| settle_sel | input | 2 | Settling code: filter shift and auto-lock interval |
| chip_valid | output | 1 | One-cycle pulse when a chip decision is ready |
| chip_out | output | 1 | Decided chip value |
| threshold | output | SMP_W | Current averaging-filter threshold |
| locked | output | 1 | Filter is frozen |

## Verification
The interesting cycle is the one in which the final strobe of the auto-lock chip arrives. In that cycle the filter takes its last update, the chip vote completes, and the lock engages, all at the same edge. The next strobe must already see the frozen threshold. The bench sweeps all four settling codes in automatic mode through this boundary. It uses preamble-like and pseudo-random samples and inserts idle cycles between strobes. A bench-side arithmetic model predicts, after every edge, the threshold, the chip pulse and value, and the lock state. A second collision is provoked by dropping `rx_en` in the middle of a chip while strobes keep arriving: the clear must win over both the update and the vote.

// File: rtl/slicer_pkg.sv
// Shared types and constants for the chip slicer.
package slicer_pkg;
    // Lock control selection.
    typedef enum logic {
        LOCK_AUTO   = 1'b0,
        LOCK_MANUAL = 1'b1
    } lock_mode_e;

    // Width of the settling code.
    localparam int unsigned SETTLE_W = 2;
endpackage

// File: rtl/slicer_avg_filter.sv
// Exponential averaging filter producing the slice threshold.
// Assumes samples are signed; the average never leaves the range spanned by
// zero and the samples seen, so it fits the sample width.
module slicer_avg_filter #(
    parameter int SMP_W = 12,
    parameter int K_MIN = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rx_en,
    input  logic                          smp_valid,
    input  logic signed [SMP_W-1:0]       smp_data,
    input  logic                          frozen,
    input  logic [slicer_pkg::SETTLE_W-1:0] settle_sel,
    output logic signed [SMP_W-1:0]       avg_o
);
    localparam int EXT_W = SMP_W + 1;

    logic signed [SMP_W-1:0] avg_q;
    logic signed [EXT_W-1:0] diff;
    logic signed [EXT_W-1:0] step;
    logic signed [EXT_W-1:0] sum;
    logic [3:0]              shift;

    // Compute the filter step for the current sample.
    always_comb begin
        shift = 4'(K_MIN) + 4'(settle_sel);
        diff  = EXT_W'(smp_data) - EXT_W'(avg_q);
        step  = diff >>> shift;
        sum   = EXT_W'(avg_q) + step;
    end

    // Hold, update or clear the average.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            avg_q <= '0;
        end else if (smp_valid && !frozen) begin
            avg_q <= sum[SMP_W-1:0];
        end
    end

    assign avg_o = avg_q;

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && smp_valid && !frozen) |-> (sum[SMP_W] == sum[SMP_W-1]))
        else $error("average overflow");

    p_hold_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && rx_en) |=> $stable(avg_q))
        else $error("average moved while frozen");

    p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (avg_q == '0))
        else $error("average not cleared when idle");
endmodule

// File: rtl/slicer_chip_vote.sv
// Per-sample comparison and majority vote over the central samples of a chip.
// Assumes OSR samples per chip, phase counted from the rise of rx_en.
module slicer_chip_vote #(
    parameter int SMP_W  = 12,
    parameter int OSR    = 8,
    parameter int VOTE_N = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_en,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_data,
    input  logic signed [SMP_W-1:0] threshold,
    output logic                    chip_end,
    output logic                    chip_valid,
    output logic                    chip_out
);
    localparam int PH_W       = $clog2(OSR);
    localparam int VOTE_FIRST = (OSR - VOTE_N + 1) / 2;
    localparam int VOTE_LAST  = VOTE_FIRST + VOTE_N - 1;
    localparam int CNT_W      = $clog2(VOTE_N + 1);
    localparam int MAJ        = (VOTE_N + 1) / 2;

    logic [PH_W-1:0]  phase_q;
    logic [CNT_W-1:0] votes_q;
    logic             above;
    logic             in_window;

    // Compare the sample and decide whether it votes.
    always_comb begin
        above     = smp_data > threshold;
        in_window = (int'(phase_q) >= VOTE_FIRST) && (int'(phase_q) <= VOTE_LAST);
        chip_end  = rx_en && smp_valid && (int'(phase_q) == OSR - 1);
    end

    // Advance phase, accumulate votes and emit the chip decision.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            phase_q    <= '0;
            votes_q    <= '0;
            chip_valid <= 1'b0;
            chip_out   <= 1'b0;
        end else begin
            chip_valid <= chip_end;
            if (smp_valid) begin
                phase_q <= (int'(phase_q) == OSR - 1) ? '0 : phase_q + 1'b1;
                if (chip_end) begin
                    chip_out <= (int'(votes_q) >= MAJ);
                    votes_q  <= '0;
                end else if (in_window && above) begin
                    votes_q <= votes_q + 1'b1;
                end
            end
        end
    end

    p_chip_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chip_valid |=> !chip_valid)
        else $error("chip pulse too long");

    p_votes_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(votes_q) <= VOTE_N)
        else $error("vote count out of range");
endmodule

// File: rtl/slicer_lock_ctrl.sv
// Lock control: manual request, or automatic lock after a chip count that
// starts with rx_en. Assumes chip_end pulses once per completed chip.
module slicer_lock_ctrl #(
    parameter int BASE_CHIPS = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rx_en,
    input  logic                            chip_end,
    input  logic                            lock_mode,
    input  logic                            lock_req,
    input  logic [slicer_pkg::SETTLE_W-1:0] settle_sel,
    output logic                            locked
);
    import slicer_pkg::*;

    localparam int MAX_SHIFT = (1 << SETTLE_W) - 1;
    localparam int CNT_W     = $clog2(BASE_CHIPS << MAX_SHIFT) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             auto_done;
    lock_mode_e       mode;

    // Derive the interval and the lock state.
    always_comb begin
        limit  = CNT_W'(BASE_CHIPS) << settle_sel;
        mode   = lock_mode_e'(lock_mode);
        locked = rx_en && ((mode == LOCK_MANUAL) ? lock_req : auto_done);
    end

    // Count chips since rx_en and latch the automatic lock.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            cnt_q     <= '0;
            auto_done <= 1'b0;
        end else if (chip_end && !auto_done) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q + 1'b1 == limit) begin
                auto_done <= 1'b1;
            end
        end
    end

    p_auto_at_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(auto_done) |-> (cnt_q == limit))
        else $error("auto lock at wrong count");

    p_auto_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_done && rx_en) |=> auto_done)
        else $error("auto lock released while receiving");
endmodule

// File: rtl/fsk_slicer.sv
// Top of the chip slicer: averaging threshold, majority vote and lock control.
// Assumes one discriminator sample per strobe and OSR strobes per chip.
module fsk_slicer #(
    parameter int SMP_W      = 12,
    parameter int OSR        = 8,
    parameter int VOTE_N     = 5,
    parameter int BASE_CHIPS = 16,
    parameter int K_MIN      = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_en,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_data,
    input  logic                    lock_mode,
    input  logic                    lock_req,
    input  logic [1:0]              settle_sel,
    output logic                    chip_valid,
    output logic                    chip_out,
    output logic signed [SMP_W-1:0] threshold,
    output logic                    locked
);
    logic chip_end;

    slicer_avg_filter #(.SMP_W(SMP_W), .K_MIN(K_MIN)) u_filter (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .smp_valid(smp_valid),
        .smp_data(smp_data), .frozen(locked), .settle_sel(settle_sel),
        .avg_o(threshold)
    );

    slicer_chip_vote #(.SMP_W(SMP_W), .OSR(OSR), .VOTE_N(VOTE_N)) u_vote (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .smp_valid(smp_valid),
        .smp_data(smp_data), .threshold(threshold), .chip_end(chip_end),
        .chip_valid(chip_valid), .chip_out(chip_out)
    );

    slicer_lock_ctrl #(.BASE_CHIPS(BASE_CHIPS)) u_lock (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .chip_end(chip_end),
        .lock_mode(lock_mode), .lock_req(lock_req), .settle_sel(settle_sel),
        .locked(locked)
    );

    p_idle_unlocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !chip_valid)
        else $error("chip pulse while idle");
endmodule

// File: tb/fsk_slicer_tb_top.sv
module fsk_slicer_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_en = 1'b0;
    logic              smp_valid = 1'b0;
    logic signed [11:0] smp_data = '0;
    logic              lock_mode = 1'b0;
    logic              lock_req = 1'b0;
    logic [1:0]        settle_sel = 2'd0;
    logic              chip_valid;
    logic              chip_out;
    logic signed [11:0] threshold;
    logic              locked;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // bench model state
    int  m_avg = 0, m_phase = 0, m_votes = 0, m_cnt = 0;
    bit  m_done = 0;
    int unsigned lfsr = 32'h1234_5678;

    always #10 clk = ~clk;

    fsk_slicer dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .smp_valid(smp_valid),
        .smp_data(smp_data), .lock_mode(lock_mode), .lock_req(lock_req),
        .settle_sel(settle_sel), .chip_valid(chip_valid), .chip_out(chip_out),
        .threshold(threshold), .locked(locked)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int next_rand();
        lfsr = lfsr * 32'd1103515245 + 32'd12345;
        return int'((lfsr >> 16) % 32'd801) - 400;
    endfunction

    function automatic void model_clear();
        m_avg = 0; m_phase = 0; m_votes = 0; m_cnt = 0; m_done = 0;
    endfunction

    // Drive one cycle at negedge, predict, and check at the next negedge.
    task automatic step(input bit v, input int x);
        bit lk, exp_cv, exp_co, cmp;
        string lt;
        smp_valid = v;
        smp_data  = 12'(x);
        exp_cv = 0; exp_co = 0;
        lk = rx_en && (lock_mode ? lock_req : m_done);
        if (!rx_en) begin
            model_clear();
        end else if (v) begin
            cmp = (x > m_avg);
            if (m_phase >= 2 && m_phase <= 6 && cmp) m_votes++;
            if (m_phase == 7) begin
                exp_cv = 1;
                exp_co = (m_votes >= 3);
                m_votes = 0;
                if (!m_done) begin
                    m_cnt++;
                    if (m_cnt == (16 << settle_sel)) m_done = 1;
                end
            end
            m_phase = (m_phase + 1) % 8;
            if (!lk) m_avg = m_avg + ((x - m_avg) >>> (3 + settle_sel));
        end
        @(posedge clk);
        @(negedge clk);
        if (!rx_en) begin
            check(threshold == 0, "R8", int'(threshold), 0);
            check(locked == 0, "R8", int'(locked), 0);
            check(chip_valid == 0, "R8", int'(chip_valid), 0);
        end else begin
            check(int'(threshold) == m_avg, lk ? "R7" : "R2", int'(threshold), m_avg);
            check(chip_valid == exp_cv, "R4", int'(chip_valid), int'(exp_cv));
            if (exp_cv) check(chip_out == exp_co, "R3", int'(chip_out), int'(exp_co));
            lt = lock_mode ? "R5" : (lock_req ? "R9" : "R6");
            check(locked == (lock_mode ? lock_req : m_done), lt, int'(locked),
                  int'(lock_mode ? lock_req : m_done));
        end
    endtask

    // One chip of preamble-like samples around a DC offset, with idle gaps.
    task automatic send_chip(input int idx, input int dc, input bit noisy);
        for (int s = 0; s < 8; s++) begin
            int x;
            x = dc + ((idx % 2) ? 300 : -300);
            if (noisy) x = dc + next_rand();
            step(1'b1, x);
            if (s == 3 && (idx % 3 == 0)) step(1'b0, 0);
        end
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(threshold == 0, "R1", int'(threshold), 0);
        check(locked == 0, "R1", int'(locked), 0);
        check(chip_valid == 0, "R1", int'(chip_valid), 0);

        // R8: samples while idle have no effect
        for (int i = 0; i < 10; i++) step(1'b1, 700);

        // R6/R2/R3/R4/R7: automatic lock for every settling code
        for (int s = 0; s < 4; s++) begin
            settle_sel = 2'(s);
            lock_mode  = 1'b0;
            rx_en = 1'b0; step(1'b0, 0);
            rx_en = 1'b1;
            for (int c = 0; c < (16 << s) + 4; c++) begin
                lock_req = (c % 5 == 2);   // R9: ignored in automatic mode
                send_chip(c, 120 - 60 * s, (c % 4 == 3));
            end
            check(locked == 1, "R6", int'(locked), 1);
        end

        // R5: manual mode, free running then locked then free again
        lock_mode = 1'b1; lock_req = 1'b0; settle_sel = 2'd1;
        rx_en = 1'b0; step(1'b0, 0);
        rx_en = 1'b1;
        for (int c = 0; c < 40; c++) send_chip(c, -80, c > 20);
        lock_req = 1'b1;
        for (int c = 0; c < 12; c++) send_chip(c, 200, 1'b1);
        lock_req = 1'b0;
        for (int c = 0; c < 12; c++) send_chip(c, 200, 1'b0);

        // R8: drop rx_en mid-chip while strobes continue, then restart
        lock_mode = 1'b0; settle_sel = 2'd0;
        for (int i = 0; i < 5; i++) step(1'b1, next_rand());
        rx_en = 1'b0; step(1'b1, 500);
        rx_en = 1'b1;
        for (int c = 0; c < 20; c++) send_chip(c, 50, 1'b1);

        // R3: equal-to-threshold samples vote 0 while locked
        for (int i = 0; i < 8; i++) step(1'b1, m_avg);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule